// File: doc/BRIEF.md
# Dual-Bank Arithmetic and Logic Unit

This block is the purely combinational arithmetic and logic stage of a small microcoded processor with a 32-bit datapath. A 3-bit operation code together with a single bank-select bit chooses one of sixteen behaviours. Bank 0 holds the arithmetic and data-movement group: store, load, plain add and subtract, index-style add and subtract, and a carry-add into the operand. Bank 1 holds the logical group: exclusive-or, AND, OR, the bit test, a carry-add into the complemented operand, and add and subtract that take the carry flag in. Each bank has one code that does nothing.

The sequencer supplies the accumulator, the fetched operand, the operand size (byte, short or word) and the current carry, zero and sign flags. The block returns the sized result, a register write-back enable, and the next values of the three flags. Some codes only pass data through or test it. These codes hold write-back low or keep flags unchanged. A parameter selects the adder structure: a plain rippled chain, or per-segment carry-select.

Top module: `dual_bank_alu`

## Requirements
- R1: Encoding with carry_sel=0, alu_op 0..7: store, none, index-subtract, index-add, load, carry-add, subtract, add. With carry_sel=1, alu_op 0..7: none, XOR, bit-test, AND, OR, carry-add-complement, subtract-with-carry, add-with-carry. Add gives result = acc+opnd with c_out = carry out of the sized width, and add-with-carry also adds c_in.
- R2: Subtract gives acc + ~opnd + 1, and subtract-with-carry gives acc + ~opnd + c_in. In both, c_out is the carry out of the sized width, so 1 means no borrow.
- R3: Index-add and index-subtract produce the same result as add and subtract, assert wr_en, and keep c_out equal to c_in.
- R4: Carry-add gives opnd + c_in. Carry-add-complement gives ~opnd + c_in. Both write c_out from the carry out of the sized width.
- R5: XOR, AND and OR give the bitwise result with wr_en high and c_out equal to c_in.
- R6: Bit-test computes acc AND opnd on result and updates z_out and s_out from it. It holds wr_en low and keeps c_out equal to c_in.
- R7: Load gives result = opnd with wr_en high and c_out equal to c_in.
- R8: Store gives result = acc for the memory write. It holds wr_en low, and all three flag outputs equal their inputs.
- R9: Both none codes hold wr_en low and pass all three flags through unchanged.
- R10: size_sel 0 selects 8 bits, 1 selects 16 bits, and 2 or 3 selects 32 bits. Result bits above the selected size are 0, and arithmetic carry is taken at the top of the selected size.
- R11: On every code except store and none, z_out is 1 exactly when the sized result is zero, and s_out equals its top bit (bit 7, 15 or 31).
- R12: The rippled and carry-select adder variants give identical outputs for every input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| alu_op | input | 3 | Operation code within the selected bank |
| carry_sel | input | 1 | Bank select: 0 arithmetic/move bank, 1 logical bank |
| size_sel | input | 2 | Operand size: 0 byte, 1 short, 2/3 word |
| acc_in | input | 32 | Accumulator value |
| opnd_in | input | 32 | Operand value |
| c_in | input | 1 | Current carry flag |
| z_in | input | 1 | Current zero flag |
| s_in | input | 1 | Current sign flag |
| result | output | 32 | Sized result, zero above the selected size |
| wr_en | output | 1 | Register write-back enable |
| c_out | output | 1 | Next carry flag |
| z_out | output | 1 | Next zero flag |
| s_out | output | 1 | Next sign flag |

## Verification
The bench builds the block at its default 32-bit width with 8-bit adder segments, and builds it twice: once with carry-select and once rippled. Driving both from the same stimulus makes every adder boundary between segments reachable as a difference between the two structures. The 8- and 16-bit operand sizes line up with segment boundaries, so vectors such as 0xFF+1 at byte size and 0xFFFF+1 at short size show whether the carry tap sits at the right segment. A pseudo-random sweep across all sixteen codes and the four size values adds to the directed cases.

// File: rtl/dbalu_pkg.sv
package dbalu_pkg;

   typedef enum logic [1:0] {
      CIN_ZERO = 2'd0,
      CIN_ONE  = 2'd1,
      CIN_FLAG = 2'd2
   } cin_src_e;

   typedef enum logic [1:0] {
      SRC_ADDER = 2'd0,
      SRC_LOGIC = 2'd1,
      SRC_ACC   = 2'd2,
      SRC_OPND  = 2'd3
   } res_src_e;

   typedef enum logic [1:0] {
      LG_AND = 2'd0,
      LG_OR  = 2'd1,
      LG_XOR = 2'd2
   } logic_fn_e;

   typedef struct packed {
      logic      x_zero;
      logic      y_inv;
      cin_src_e  cin;
      res_src_e  src;
      logic_fn_e lfn;
      logic      wb;
      logic      upd_c;
      logic      upd_zs;
   } alu_ctrl_t;

endpackage

// File: rtl/dbalu_decode.sv
module dbalu_decode
   import dbalu_pkg::*;
(
   input  logic       carry_sel,
   input  logic [2:0] alu_op,
   output alu_ctrl_t  ctrl
);

   always_comb begin
      ctrl        = '0;
      ctrl.cin    = CIN_ZERO;
      ctrl.src    = SRC_ADDER;
      ctrl.lfn    = LG_AND;
      case ({carry_sel, alu_op})
         4'b0_000: begin // store: accumulator out, nothing written back
            ctrl.src = SRC_ACC;
         end
         4'b0_001: begin // none
            ctrl.src = SRC_ACC;
         end
         4'b0_010: begin // index subtract
            ctrl.y_inv  = 1'b1;
            ctrl.cin    = CIN_ONE;
            ctrl.wb     = 1'b1;
            ctrl.upd_zs = 1'b1;
         end
         4'b0_011: begin // index add
            ctrl.wb     = 1'b1;
            ctrl.upd_zs = 1'b1;
         end
         4'b0_100: begin // load
            ctrl.src    = SRC_OPND;
            ctrl.wb     = 1'b1;
            ctrl.upd_zs = 1'b1;
         end
         4'b0_101: begin // carry into operand
            ctrl.x_zero = 1'b1;
            ctrl.cin    = CIN_FLAG;
            ctrl.wb     = 1'b1;
            ctrl.upd_c  = 1'b1;
            ctrl.upd_zs = 1'b1;
         end
         4'b0_110: begin // subtract
            ctrl.y_inv  = 1'b1;
            ctrl.cin    = CIN_ONE;
            ctrl.wb     = 1'b1;
            ctrl.upd_c  = 1'b1;
            ctrl.upd_zs = 1'b1;
         end
         4'b0_111: begin // add
            ctrl.wb     = 1'b1;
            ctrl.upd_c  = 1'b1;
            ctrl.upd_zs = 1'b1;
         end
         4'b1_000: begin // none
            ctrl.src = SRC_ACC;
         end
         4'b1_001: begin // xor
            ctrl.src    = SRC_LOGIC;
            ctrl.lfn    = LG_XOR;
            ctrl.wb     = 1'b1;
            ctrl.upd_zs = 1'b1;
         end
         4'b1_010: begin // bit test: flags only
            ctrl.src    = SRC_LOGIC;
            ctrl.lfn    = LG_AND;
            ctrl.upd_zs = 1'b1;
         end
         4'b1_011: begin // and
            ctrl.src    = SRC_LOGIC;
            ctrl.lfn    = LG_AND;
            ctrl.wb     = 1'b1;
            ctrl.upd_zs = 1'b1;
         end
         4'b1_100: begin // or
            ctrl.src    = SRC_LOGIC;
            ctrl.lfn    = LG_OR;
            ctrl.wb     = 1'b1;
            ctrl.upd_zs = 1'b1;
         end
         4'b1_101: begin // carry into complemented operand
            ctrl.x_zero = 1'b1;
            ctrl.y_inv  = 1'b1;
            ctrl.cin    = CIN_FLAG;
            ctrl.wb     = 1'b1;
            ctrl.upd_c  = 1'b1;
            ctrl.upd_zs = 1'b1;
         end
         4'b1_110: begin // subtract with carry as not-borrow
            ctrl.y_inv  = 1'b1;
            ctrl.cin    = CIN_FLAG;
            ctrl.wb     = 1'b1;
            ctrl.upd_c  = 1'b1;
            ctrl.upd_zs = 1'b1;
         end
         default: begin // add with carry
            ctrl.cin    = CIN_FLAG;
            ctrl.wb     = 1'b1;
            ctrl.upd_c  = 1'b1;
            ctrl.upd_zs = 1'b1;
         end
      endcase
   end

endmodule

// File: rtl/dbalu_adder.sv
module dbalu_adder #(
   parameter int WIDTH      = 32,
   parameter int SEG_W      = 8,
   parameter int BYTE_W     = 8,
   parameter int SHORT_W    = 16,
   parameter bit USE_SELECT = 1'b1
) (
   input  logic [WIDTH-1:0] x,
   input  logic [WIDTH-1:0] y,
   input  logic             cin,
   output logic [WIDTH-1:0] sum,
   output logic             co_byte,
   output logic             co_short,
   output logic             co_word
);

   localparam int NSEG      = WIDTH / SEG_W;
   localparam int BYTE_SEG  = BYTE_W / SEG_W;
   localparam int SHORT_SEG = SHORT_W / SEG_W;

   for (genvar g = 0; g < NSEG; g++) begin : g_seg
      logic             ci;
      logic             co;
      logic [SEG_W-1:0] xs;
      logic [SEG_W-1:0] ys;

      assign xs = x[g*SEG_W +: SEG_W];
      assign ys = y[g*SEG_W +: SEG_W];

      if (g == 0) begin : g_first
         assign ci = cin;
      end else begin : g_next
         assign ci = g_seg[g-1].co;
      end

      if (USE_SELECT) begin : g_sel
         logic [SEG_W:0] r0;
         logic [SEG_W:0] r1;
         assign r0 = {1'b0, xs} + {1'b0, ys};
         assign r1 = {1'b0, xs} + {1'b0, ys} + {{SEG_W{1'b0}}, 1'b1};
         assign sum[g*SEG_W +: SEG_W] = ci ? r1[SEG_W-1:0] : r0[SEG_W-1:0];
         assign co = ci ? r1[SEG_W] : r0[SEG_W];
      end else begin : g_rip
         logic [SEG_W:0] r;
         assign r = {1'b0, xs} + {1'b0, ys} + {{SEG_W{1'b0}}, ci};
         assign sum[g*SEG_W +: SEG_W] = r[SEG_W-1:0];
         assign co = r[SEG_W];
      end
   end

   assign co_byte  = g_seg[BYTE_SEG-1].co;
   assign co_short = g_seg[SHORT_SEG-1].co;
   assign co_word  = g_seg[NSEG-1].co;

endmodule

// File: rtl/dbalu_flags.sv
module dbalu_flags #(
   parameter int WIDTH   = 32,
   parameter int BYTE_W  = 8,
   parameter int SHORT_W = 16
) (
   input  logic [WIDTH-1:0] raw,
   input  logic [1:0]       size_sel,
   input  logic             co_byte,
   input  logic             co_short,
   input  logic             co_word,
   input  logic             upd_c,
   input  logic             upd_zs,
   input  logic             c_in,
   input  logic             z_in,
   input  logic             s_in,
   output logic [WIDTH-1:0] result,
   output logic             c_out,
   output logic             z_out,
   output logic             s_out
);

   localparam logic [WIDTH-1:0] MASK_B = {{(WIDTH-BYTE_W){1'b0}}, {BYTE_W{1'b1}}};
   localparam logic [WIDTH-1:0] MASK_S = {{(WIDTH-SHORT_W){1'b0}}, {SHORT_W{1'b1}}};

   logic [WIDTH-1:0] mask;
   logic             tap_c;
   logic             top_bit;

   always_comb begin
      case (size_sel)
         2'd0: begin
            mask    = MASK_B;
            tap_c   = co_byte;
            top_bit = raw[BYTE_W-1];
         end
         2'd1: begin
            mask    = MASK_S;
            tap_c   = co_short;
            top_bit = raw[SHORT_W-1];
         end
         default: begin
            mask    = '1;
            tap_c   = co_word;
            top_bit = raw[WIDTH-1];
         end
      endcase
   end

   assign result = raw & mask;
   assign c_out  = upd_c  ? tap_c         : c_in;
   assign z_out  = upd_zs ? (result == '0) : z_in;
   assign s_out  = upd_zs ? top_bit       : s_in;

endmodule

// File: rtl/dual_bank_alu.sv
module dual_bank_alu
   import dbalu_pkg::*;
#(
   parameter int WIDTH      = 32,
   parameter int SEG_W      = 8,
   parameter int BYTE_W     = 8,
   parameter int SHORT_W    = 16,
   parameter bit USE_SELECT = 1'b1
) (
   input  logic [2:0]       alu_op,
   input  logic             carry_sel,
   input  logic [1:0]       size_sel,
   input  logic [WIDTH-1:0] acc_in,
   input  logic [WIDTH-1:0] opnd_in,
   input  logic             c_in,
   input  logic             z_in,
   input  logic             s_in,
   output logic [WIDTH-1:0] result,
   output logic             wr_en,
   output logic             c_out,
   output logic             z_out,
   output logic             s_out
);

   if (WIDTH % SEG_W != 0) begin : g_bad_seg
      $error("WIDTH must be a multiple of SEG_W");
   end
   if ((BYTE_W % SEG_W != 0) || (SHORT_W % SEG_W != 0)) begin : g_bad_tap
      $error("BYTE_W and SHORT_W must sit on SEG_W boundaries");
   end
   if (!(BYTE_W > 0 && BYTE_W < SHORT_W && SHORT_W < WIDTH)) begin : g_bad_sizes
      $error("sizes must satisfy 0 < BYTE_W < SHORT_W < WIDTH");
   end

   alu_ctrl_t        ctrl;
   logic [WIDTH-1:0] add_x;
   logic [WIDTH-1:0] add_y;
   logic             add_cin;
   logic [WIDTH-1:0] add_sum;
   logic             co_byte;
   logic             co_short;
   logic             co_word;
   logic [WIDTH-1:0] lg_res;
   logic [WIDTH-1:0] raw;

   dbalu_decode u_decode (
      .carry_sel (carry_sel),
      .alu_op    (alu_op),
      .ctrl      (ctrl)
   );

   assign add_x = ctrl.x_zero ? '0 : acc_in;
   assign add_y = ctrl.y_inv ? ~opnd_in : opnd_in;

   always_comb begin
      case (ctrl.cin)
         CIN_ONE:  add_cin = 1'b1;
         CIN_FLAG: add_cin = c_in;
         default:  add_cin = 1'b0;
      endcase
   end

   dbalu_adder #(
      .WIDTH      (WIDTH),
      .SEG_W      (SEG_W),
      .BYTE_W     (BYTE_W),
      .SHORT_W    (SHORT_W),
      .USE_SELECT (USE_SELECT)
   ) u_adder (
      .x        (add_x),
      .y        (add_y),
      .cin      (add_cin),
      .sum      (add_sum),
      .co_byte  (co_byte),
      .co_short (co_short),
      .co_word  (co_word)
   );

   always_comb begin
      case (ctrl.lfn)
         LG_OR:   lg_res = acc_in | opnd_in;
         LG_XOR:  lg_res = acc_in ^ opnd_in;
         default: lg_res = acc_in & opnd_in;
      endcase
   end

   always_comb begin
      case (ctrl.src)
         SRC_LOGIC: raw = lg_res;
         SRC_ACC:   raw = acc_in;
         SRC_OPND:  raw = opnd_in;
         default:   raw = add_sum;
      endcase
   end

   dbalu_flags #(
      .WIDTH   (WIDTH),
      .BYTE_W  (BYTE_W),
      .SHORT_W (SHORT_W)
   ) u_flags (
      .raw      (raw),
      .size_sel (size_sel),
      .co_byte  (co_byte),
      .co_short (co_short),
      .co_word  (co_word),
      .upd_c    (ctrl.upd_c),
      .upd_zs   (ctrl.upd_zs),
      .c_in     (c_in),
      .z_in     (z_in),
      .s_in     (s_in),
      .result   (result),
      .c_out    (c_out),
      .z_out    (z_out),
      .s_out    (s_out)
   );

   assign wr_en = ctrl.wb;

endmodule

// File: rtl/dual_bank_alu_chk.sv
module dual_bank_alu_chk #(
   parameter int WIDTH   = 32,
   parameter int BYTE_W  = 8,
   parameter int SHORT_W = 16
) (
   input logic [2:0]       alu_op,
   input logic             carry_sel,
   input logic [1:0]       size_sel,
   input logic [WIDTH-1:0] acc_in,
   input logic [WIDTH-1:0] opnd_in,
   input logic             c_in,
   input logic             z_in,
   input logic             s_in,
   input logic [WIDTH-1:0] result,
   input logic             wr_en,
   input logic             c_out,
   input logic             z_out,
   input logic             s_out
);

   logic [WIDTH-1:0] m;
   logic             top;
   logic             is_store;
   logic             is_none;

   always_comb begin
      m   = '1;
      top = result[WIDTH-1];
      if (size_sel == 2'd0) begin
         m   = {{(WIDTH-BYTE_W){1'b0}}, {BYTE_W{1'b1}}};
         top = result[BYTE_W-1];
      end else if (size_sel == 2'd1) begin
         m   = {{(WIDTH-SHORT_W){1'b0}}, {SHORT_W{1'b1}}};
         top = result[SHORT_W-1];
      end
      is_store = (carry_sel == 1'b0) && (alu_op == 3'd0);
      is_none  = ({carry_sel, alu_op} == 4'b0_001) || ({carry_sel, alu_op} == 4'b1_000);
   end

   always_comb begin
      assert_store_pass_R8: assert (!is_store ||
         (!wr_en && result == (acc_in & m) && c_out == c_in && z_out == z_in && s_out == s_in))
         else $error("store behaviour violated");
      assert_none_hold_R9: assert (!is_none ||
         (!wr_en && c_out == c_in && z_out == z_in && s_out == s_in))
         else $error("none code changed state");
      assert_index_keep_c_R3: assert (!(carry_sel == 1'b0 && (alu_op == 3'd2 || alu_op == 3'd3)) ||
         (wr_en && c_out == c_in))
         else $error("index op touched carry");
      assert_bit_no_wb_R6: assert (!(carry_sel == 1'b1 && alu_op == 3'd2) ||
         (!wr_en && result == (acc_in & opnd_in & m) && c_out == c_in))
         else $error("bit test wrong");
      assert_load_pass_R7: assert (!(carry_sel == 1'b0 && alu_op == 3'd4) ||
         (wr_en && result == (opnd_in & m) && c_out == c_in))
         else $error("load wrong");
      assert_upper_clear_R10: assert ((result & ~m) == '0)
         else $error("bits above size not clear");
      assert_zs_flags_R11: assert (is_store || is_none ||
         (z_out == (result == '0) && s_out == top))
         else $error("zero/sign flag mismatch");
   end

endmodule

bind dual_bank_alu dual_bank_alu_chk #(
   .WIDTH   (WIDTH),
   .BYTE_W  (BYTE_W),
   .SHORT_W (SHORT_W)
) i_chk (
   .alu_op    (alu_op),
   .carry_sel (carry_sel),
   .size_sel  (size_sel),
   .acc_in    (acc_in),
   .opnd_in   (opnd_in),
   .c_in      (c_in),
   .z_in      (z_in),
   .s_in      (s_in),
   .result    (result),
   .wr_en     (wr_en),
   .c_out     (c_out),
   .z_out     (z_out),
   .s_out     (s_out)
);

// File: tb/test_dual_bank_alu.sv
`timescale 1ns/1ps
module test_dual_bank_alu;

   typedef struct {
      logic [31:0] res;
      logic        wb;
      logic        c;
      logic        z;
      logic        s;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [2:0]  alu_op = 3'd1;
   logic        carry_sel = 1'b0;
   logic [1:0]  size_sel = 2'd2;
   logic [31:0] acc_in = '0;
   logic [31:0] opnd_in = '0;
   logic        c_in = 1'b0;
   logic        z_in = 1'b0;
   logic        s_in = 1'b0;
   logic [31:0] result, result_r;
   logic        wr_en, c_out, z_out, s_out;
   logic        wr_en_r, c_out_r, z_out_r, s_out_r;

   int checks   = 0;
   int failures = 0;
   exp_t q[$];

   always #10 clk = ~clk;

   dual_bank_alu #(.USE_SELECT(1'b1)) i_dual_bank_alu (
      .alu_op(alu_op), .carry_sel(carry_sel), .size_sel(size_sel),
      .acc_in(acc_in), .opnd_in(opnd_in), .c_in(c_in), .z_in(z_in), .s_in(s_in),
      .result(result), .wr_en(wr_en), .c_out(c_out), .z_out(z_out), .s_out(s_out));

   dual_bank_alu #(.USE_SELECT(1'b0)) i_dual_bank_alu_ripple (
      .alu_op(alu_op), .carry_sel(carry_sel), .size_sel(size_sel),
      .acc_in(acc_in), .opnd_in(opnd_in), .c_in(c_in), .z_in(z_in), .s_in(s_in),
      .result(result_r), .wr_en(wr_en_r), .c_out(c_out_r), .z_out(z_out_r), .s_out(s_out_r));

   function automatic string tag_of(logic cs, logic [2:0] op);
      case ({cs, op})
         4'b0_000: return "R8";
         4'b0_001, 4'b1_000: return "R9";
         4'b0_010, 4'b0_011: return "R3";
         4'b0_100: return "R7";
         4'b0_101, 4'b1_101: return "R4";
         4'b0_110, 4'b1_110: return "R2";
         4'b1_010: return "R6";
         4'b1_001, 4'b1_011, 4'b1_100: return "R5";
         default: return "R1";
      endcase
   endfunction

   // Reference model written from the requirement list
   function automatic exp_t model(logic cs, logic [2:0] op, logic [1:0] sz,
                                  logic [31:0] a, logic [31:0] b,
                                  logic ci, logic zi, logic si);
      exp_t e;
      int w;
      longint unsigned m, am, bm, s;
      logic carry_new, upd_c, upd_zs;
      w  = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
      m  = (64'd1 << w) - 1;
      am = a & m;
      bm = b & m;
      s  = 0;
      upd_c = 1'b0; upd_zs = 1'b1; e.wb = 1'b1;
      case ({cs, op})
         4'b0_000: begin s = am; e.wb = 0; upd_zs = 0; end
         4'b0_001, 4'b1_000: begin s = am; e.wb = 0; upd_zs = 0; end
         4'b0_010: s = am + (~bm & m) + 1;
         4'b0_011: s = am + bm;
         4'b0_100: s = bm;
         4'b0_101: begin s = bm + ci; upd_c = 1; end
         4'b0_110: begin s = am + (~bm & m) + 1; upd_c = 1; end
         4'b0_111: begin s = am + bm; upd_c = 1; end
         4'b1_001: s = am ^ bm;
         4'b1_010: begin s = am & bm; e.wb = 0; end
         4'b1_011: s = am & bm;
         4'b1_100: s = am | bm;
         4'b1_101: begin s = (~bm & m) + ci; upd_c = 1; end
         4'b1_110: begin s = am + (~bm & m) + ci; upd_c = 1; end
         default:  begin s = am + bm + ci; upd_c = 1; end
      endcase
      carry_new = s[w];
      e.res = 32'(s & m);
      e.c   = upd_c ? carry_new : ci;
      e.z   = upd_zs ? (e.res == 0) : zi;
      e.s   = upd_zs ? e.res[w-1] : si;
      e.tag = tag_of(cs, op);
      return e;
   endfunction

   task automatic apply(logic cs, logic [2:0] op, logic [1:0] sz,
                        logic [31:0] a, logic [31:0] b,
                        logic ci, logic zi, logic si, string extra);
      exp_t e;
      @(posedge clk);
      #1;
      carry_sel = cs; alu_op = op; size_sel = sz;
      acc_in = a; opnd_in = b; c_in = ci; z_in = zi; s_in = si;
      e = model(cs, op, sz, a, b, ci, zi, si);
      if (extra != "") e.tag = {e.tag, "/", extra};
      q.push_back(e);
   endtask

   // Monitor: compares away from the driving edge
   always @(negedge clk) begin
      if (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         checks++;
         if (result !== e.res || wr_en !== e.wb || c_out !== e.c || z_out !== e.z || s_out !== e.s) begin
            failures++;
            $display("FAIL %s: got res=%h wb=%b c=%b z=%b s=%b exp res=%h wb=%b c=%b z=%b s=%b",
                     e.tag, result, wr_en, c_out, z_out, s_out, e.res, e.wb, e.c, e.z, e.s);
         end
         checks++; // R12: both adder structures agree
         if (result !== result_r || wr_en !== wr_en_r || c_out !== c_out_r ||
             z_out !== z_out_r || s_out !== s_out_r) begin
            failures++;
            $display("FAIL R12: select res=%h c=%b z=%b s=%b ripple res=%h c=%b z=%b s=%b",
                     result, c_out, z_out, s_out, result_r, c_out_r, z_out_r, s_out_r);
         end
      end
   end

   initial begin
      #(200000 * 20);
      failures++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [31:0] lfsr;
      lfsr = 32'hACE1_2345;
      repeat (3) @(posedge clk);
      rst = 1'b0;
      // initial state: none code, flags held (R9)
      apply(0, 3'd1, 2'd2, 32'h0, 32'h0, 1, 0, 1, "idle");
      // R1 add / add with carry
      apply(0, 3'd7, 2'd2, 32'hFFFF_FFFF, 32'h1, 0, 0, 0, "wrap");
      apply(1, 3'd7, 2'd2, 32'h7FFF_FFFF, 32'h0, 1, 0, 0, "adc");
      // R10 byte and short carry taps
      apply(0, 3'd7, 2'd0, 32'h1234_56FF, 32'h1, 0, 0, 0, "R10 byte");
      apply(0, 3'd7, 2'd1, 32'h0000_FFFF, 32'h1, 0, 0, 0, "R10 short");
      apply(0, 3'd7, 2'd3, 32'h0000_FFFF, 32'h1, 0, 0, 0, "R10 word alt");
      // R2 subtract, borrow cases
      apply(0, 3'd6, 2'd2, 32'd5, 32'd5, 0, 0, 0, "eq");
      apply(0, 3'd6, 2'd2, 32'd3, 32'd5, 1, 0, 0, "borrow");
      apply(1, 3'd6, 2'd0, 32'h10, 32'h10, 0, 0, 0, "sbc nb=0");
      // R3 index ops keep carry
      apply(0, 3'd3, 2'd2, 32'hFFFF_FFFF, 32'h2, 0, 0, 0, "adx");
      apply(0, 3'd2, 2'd2, 32'h0, 32'h1, 1, 0, 0, "sbx");
      // R4 carry-add forms
      apply(0, 3'd5, 2'd0, 32'h0, 32'hFF, 1, 0, 0, "cad");
      apply(1, 3'd5, 2'd1, 32'h0, 32'h0, 1, 0, 0, "cac");
      // R5 logic
      apply(1, 3'd1, 2'd2, 32'hF0F0_F0F0, 32'hFFFF_0000, 1, 0, 0, "xor");
      apply(1, 3'd3, 2'd2, 32'hF0F0_F0F0, 32'h0F0F_0F0F, 0, 0, 1, "and");
      apply(1, 3'd4, 2'd0, 32'h0000_0080, 32'h1, 1, 1, 0, "or");
      // R6 bit test, R11 sign
      apply(1, 3'd2, 2'd2, 32'h8000_0001, 32'h8000_0000, 1, 1, 0, "R11 sign");
      apply(1, 3'd2, 2'd0, 32'h0000_0100, 32'h0000_01FF, 0, 0, 1, "R11 zero");
      // R7 load, R8 store
      apply(0, 3'd4, 2'd1, 32'h0, 32'hDEAD_BEEF, 1, 1, 0, "ld");
      apply(0, 3'd0, 2'd2, 32'hCAFE_F00D, 32'h1, 1, 0, 1, "st");
      apply(1, 3'd0, 2'd2, 32'h1, 32'h2, 0, 1, 1, "none1");
      // sweep over all codes and sizes
      for (int i = 0; i < 400; i++) begin
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         apply(lfsr[0], lfsr[3:1], lfsr[5:4], {lfsr[15:0], lfsr[31:16]} * 32'd2654435761,
               lfsr ^ {lfsr[7:0], lfsr[31:8]}, lfsr[9], lfsr[10], lfsr[11], "sweep");
      end
      wait (q.size() == 0);
      @(posedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule